// File: doc/BRIEF.md
# SDRAM Burst Access Sequencer

This block drives one single-data-rate SDRAM device through read and write bursts. A client request names a bank, a row, a column and a direction. The sequencer opens the row with an activate command. It waits a parameterised row-to-column delay, then issues the column command and walks the column address through the burst. On writes it moves client data onto the device data bus one clock after each beat slot. On reads it samples returning device data a parameterised CAS latency after each beat slot.

A mode load, accepted only while idle, sets two things: the burst length (1, 2, 4, 8 or a full row) and the write mode. In burst-write mode, writes follow the programmed length. In single-write mode, every write moves one beat. A full-row burst runs until the client raises a stop request. The column wraps from the top of the row to column 0 until then.

Refresh, precharge, power-down and electrical timing belong to other blocks.

Top module: `sdram_burst_seq`

## Requirements
- R1: After reset, `cmd` is NOP (code 000), `dq_oe`, `rd_valid`, `xfer_vld` and `wr_take` are low, `req_ready` is high, and the mode is burst length 1 with burst writes.
- R2: A `mode_load` in an idle cycle puts a mode-register command (code 100) on `cmd` in the next cycle, with `mode_value` on `addr`, and stores the new mode. When `mode_load` and `req_valid` are both high, the load wins and the request is not taken.
- R3: A request taken while `req_ready` is high produces an activate (code 001) in the next cycle, with `req_bank` on `ba` and the row on `addr`.
- R4: The read (code 010) or write (code 011) command appears exactly TRCD cycles after the activate cycle. It carries the same bank and the start column, zero-extended, on `addr`.
- R5: The burst length comes from `mode_value[2:0]`: 0 gives 1 beat, 1 gives 2, 2 gives 4, 3 gives 8, 7 gives a full row, and the unused codes 4, 5 and 6 give 1 beat.
- R6: In a fixed-length burst of L beats, beat i uses column `(start & ~(L-1)) | ((start + i) & (L-1))`. Beat slots appear on `xfer_vld`/`xfer_col`, and the first slot is the command cycle.
- R7: In a full-row burst, the column rises by one per beat modulo 2^COL_W. When `stop_req` is high in a beat slot, that slot is the last one, and a burst-stop command (code 101) follows in the next cycle.
- R8: `stop_req` has no effect outside a full-row burst. A fixed-length burst keeps its beat count and no burst-stop command is issued.
- R9: `wr_take` is high in every write beat slot. In the next cycle, `dq_oe` is high and `dq_out` carries the `wr_data` presented in that slot, so the first beat reaches the device one clock after the write command.
- R10: When `mode_value[9:8]` is not 00 (single-write mode), every write moves exactly one beat whatever the burst length, while reads still follow the burst length.
- R11: For each read beat slot in cycle t, `dq_in` is sampled in cycle t+CL, and `rd_valid` is high with that value on `rd_data` in cycle t+CL+1.
- R12: `req_ready` is low from the cycle after a request is taken through the last beat slot of the burst. A request presented while it is low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_load | input | 1 | Load mode register from `mode_value` (idle only) |
| mode_value | input | ADDR_W | Mode word: [2:0] burst length code, [9:8] write mode |
| req_valid | input | 1 | Burst request present |
| req_ready | output | 1 | Sequencer idle, request will be taken |
| req_write | input | 1 | 1 = write burst, 0 = read burst |
| req_bank | input | BA_W | Bank of the burst |
| req_row | input | ROW_W | Row to activate |
| req_col | input | COL_W | Start column |
| stop_req | input | 1 | Ends a full-row burst after the current beat |
| wr_data | input | DQ_W | Write data, taken when `wr_take` is high |
| wr_take | output | 1 | Write beat slot: `wr_data` is consumed this cycle |
| rd_valid | output | 1 | Read beat present on `rd_data` |
| rd_data | output | DQ_W | Read data |
| xfer_vld | output | 1 | Beat slot active |
| xfer_col | output | COL_W | Column of the current beat slot |
| cmd | output | 3 | Device command code |
| ba | output | BA_W | Device bank address |
| addr | output | ADDR_W | Device address bus |
| dq_out | output | DQ_W | Device write data |
| dq_oe | output | 1 | Device data bus driven by the sequencer |
| dq_in | input | DQ_W | Device read data |

## Verification
The bound checker checks some rules on every cycle. An accepted request is followed by an activate, and an idle mode load by a mode command. `req_ready` is low while a command is in flight. Every write slot is followed by a driven data beat that carries the taken word. A burst-stop command only follows a stopped beat slot, and full-row columns advance by one per beat. Other properties depend on the programmed mode and on where a stop lands, and only the bench scenarios can show them. These are the exact tRCD and CAS-latency placement, the aligned wrap order for each burst length, the beat count under single-write mode, the wrap at the top of a row, and the fact that stray stops and busy-time requests are ignored.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_MRS = 3'd4,
        CMD_BST = 3'd5
    } sdram_cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_TRCD  = 2'd1,
        ST_BURST = 2'd2
    } seq_state_e;

    localparam int unsigned BLCODE_W = 3;
    localparam int unsigned WMODE_W  = 2;
    localparam int unsigned BLCODE_LSB = 0;
    localparam int unsigned WMODE_LSB  = 8;

endpackage

// File: rtl/sdram_mode_reg.sv
module sdram_mode_reg
    import sdram_seq_pkg::*;
#(
    parameter int unsigned COL_W = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [BLCODE_W-1:0] bl_code,
    input  logic [WMODE_W-1:0]  wm_code,
    output logic [COL_W-1:0]    len_m1,
    output logic                full_page,
    output logic                single_wr
);

    typedef struct packed {
        logic [BLCODE_W-1:0] bl;
        logic [WMODE_W-1:0]  wm;
    } mode_t;

    mode_t mode_d, mode_q;

    always_comb begin
        mode_d = mode_q;
        if (load) begin
            mode_d.bl = bl_code;
            mode_d.wm = wm_code;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= '0;
        else        mode_q <= mode_d;
    end

    always_comb begin
        full_page = 1'b0;
        case (mode_q.bl)
            3'd1:    len_m1 = COL_W'(1);
            3'd2:    len_m1 = COL_W'(3);
            3'd3:    len_m1 = COL_W'(7);
            3'd7: begin
                len_m1    = '1;
                full_page = 1'b1;
            end
            default: len_m1 = '0;
        endcase
        single_wr = (mode_q.wm != '0);
    end

endmodule

// File: rtl/sdram_col_next.sv
module sdram_col_next #(
    parameter int unsigned COL_W = 9
) (
    input  logic [COL_W-1:0] cur,
    input  logic [COL_W-1:0] mask,
    input  logic             linear,
    output logic [COL_W-1:0] nxt
);

    logic [COL_W-1:0] inc;

    always_comb begin
        inc = cur + COL_W'(1);
        if (linear) nxt = inc;
        else        nxt = (cur & ~mask) | (inc & mask);
    end

endmodule

// File: rtl/sdram_rd_align.sv
module sdram_rd_align #(
    parameter int unsigned DQ_W = 16,
    parameter int unsigned CL   = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            slot_rd,
    input  logic [DQ_W-1:0] dq_in,
    output logic            rd_valid,
    output logic [DQ_W-1:0] rd_data
);

    typedef struct packed {
        logic [CL-1:0]   pipe;
        logic            vld;
        logic [DQ_W-1:0] data;
    } rd_t;

    rd_t r_d, r_q;
    logic [CL-1:0] pipe_shift;

    generate
        if (CL == 1) begin : g_cl1
            assign pipe_shift = slot_rd;
        end else begin : g_cln
            assign pipe_shift = {r_q.pipe[CL-2:0], slot_rd};
        end
    endgenerate

    always_comb begin
        r_d      = r_q;
        r_d.pipe = pipe_shift;
        r_d.vld  = r_q.pipe[CL-1];
        if (r_q.pipe[CL-1]) r_d.data = dq_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rd_valid = r_q.vld;
    assign rd_data  = r_q.data;

endmodule

// File: rtl/sdram_wr_path.sv
module sdram_wr_path #(
    parameter int unsigned DQ_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            take,
    input  logic [DQ_W-1:0] wr_data,
    output logic            dq_oe,
    output logic [DQ_W-1:0] dq_out
);

    typedef struct packed {
        logic            oe;
        logic [DQ_W-1:0] data;
    } wr_t;

    wr_t w_d, w_q;

    always_comb begin
        w_d    = w_q;
        w_d.oe = take;
        if (take) w_d.data = wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end

    assign dq_oe  = w_q.oe;
    assign dq_out = w_q.data;

endmodule

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq
    import sdram_seq_pkg::*;
#(
    parameter int unsigned DQ_W   = 16,
    parameter int unsigned BA_W   = 2,
    parameter int unsigned ROW_W  = 13,
    parameter int unsigned COL_W  = 9,
    parameter int unsigned ADDR_W = 14,
    parameter int unsigned TRCD   = 3,
    parameter int unsigned CL     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_load,
    input  logic [ADDR_W-1:0] mode_value,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [BA_W-1:0]   req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic              stop_req,
    input  logic [DQ_W-1:0]   wr_data,
    output logic              wr_take,
    output logic              rd_valid,
    output logic [DQ_W-1:0]   rd_data,
    output logic              xfer_vld,
    output logic [COL_W-1:0]  xfer_col,
    output logic [2:0]        cmd,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr,
    output logic [DQ_W-1:0]   dq_out,
    output logic              dq_oe,
    input  logic [DQ_W-1:0]   dq_in
);

    localparam int unsigned CNT_W = $clog2(TRCD + 1);

    typedef struct packed {
        seq_state_e        state;
        logic [CNT_W-1:0]  cnt;
        sdram_cmd_e        cmd;
        logic [BA_W-1:0]   ba;
        logic [ADDR_W-1:0] addr;
        logic [COL_W-1:0]  col;
        logic [COL_W-1:0]  left;
        logic              wr;
        logic              fpb;
        logic              slot;
    } seq_t;

    seq_t s_d, s_q;

    logic             idle;
    logic             mode_we;
    logic [COL_W-1:0] len_m1;
    logic             full_page;
    logic             single_wr;
    logic [COL_W-1:0] col_nxt;
    logic             one_beat_wr;
    logic             fp_mode;

    assign idle    = (s_q.state == ST_IDLE);
    assign mode_we = idle && mode_load;

    sdram_mode_reg #(.COL_W(COL_W)) u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (mode_we),
        .bl_code   (mode_value[BLCODE_LSB +: BLCODE_W]),
        .wm_code   (mode_value[WMODE_LSB +: WMODE_W]),
        .len_m1    (len_m1),
        .full_page (full_page),
        .single_wr (single_wr)
    );

    sdram_col_next #(.COL_W(COL_W)) u_col (
        .cur    (s_q.col),
        .mask   (len_m1),
        .linear (s_q.fpb),
        .nxt    (col_nxt)
    );

    assign one_beat_wr = s_q.wr && single_wr;

    always_comb begin
        s_d      = s_q;
        s_d.cmd  = CMD_NOP;
        s_d.slot = 1'b0;
        case (s_q.state)
            ST_IDLE: begin
                if (mode_load) begin
                    s_d.cmd  = CMD_MRS;
                    s_d.addr = mode_value;
                end else if (req_valid) begin
                    s_d.cmd   = CMD_ACT;
                    s_d.ba    = req_bank;
                    s_d.addr  = ADDR_W'(req_row);
                    s_d.col   = req_col;
                    s_d.wr    = req_write;
                    s_d.cnt   = CNT_W'(TRCD - 1);
                    s_d.state = ST_TRCD;
                end
            end
            ST_TRCD: begin
                if (s_q.cnt == '0) begin
                    s_d.cmd   = s_q.wr ? CMD_WR : CMD_RD;
                    s_d.addr  = ADDR_W'(s_q.col);
                    s_d.slot  = 1'b1;
                    s_d.fpb   = full_page && !one_beat_wr;
                    s_d.left  = one_beat_wr ? '0 : len_m1;
                    s_d.state = ST_BURST;
                end else begin
                    s_d.cnt = s_q.cnt - CNT_W'(1);
                end
            end
            ST_BURST: begin
                if (s_q.fpb) begin
                    if (stop_req) begin
                        s_d.cmd   = CMD_BST;
                        s_d.state = ST_IDLE;
                    end else begin
                        s_d.slot = 1'b1;
                        s_d.col  = col_nxt;
                    end
                end else if (s_q.left == '0) begin
                    s_d.state = ST_IDLE;
                end else begin
                    s_d.slot = 1'b1;
                    s_d.col  = col_nxt;
                    s_d.left = s_q.left - COL_W'(1);
                end
            end
            default: s_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    sdram_rd_align #(.DQ_W(DQ_W), .CL(CL)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .slot_rd  (s_q.slot && !s_q.wr),
        .dq_in    (dq_in),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    sdram_wr_path #(.DQ_W(DQ_W)) u_wr (
        .clk     (clk),
        .rst_n   (rst_n),
        .take    (wr_take),
        .wr_data (wr_data),
        .dq_oe   (dq_oe),
        .dq_out  (dq_out)
    );

    assign fp_mode   = s_q.fpb;
    assign req_ready = idle;
    assign wr_take   = s_q.slot && s_q.wr;
    assign xfer_vld  = s_q.slot;
    assign xfer_col  = s_q.col;
    assign cmd       = s_q.cmd;
    assign ba        = s_q.ba;
    assign addr      = s_q.addr;

endmodule

// File: rtl/sdram_seq_chk.sv
module sdram_seq_chk
    import sdram_seq_pkg::*;
#(
    parameter int unsigned DQ_W  = 16,
    parameter int unsigned COL_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             mode_load,
    input logic             stop_req,
    input logic [2:0]       cmd,
    input logic             xfer_vld,
    input logic [COL_W-1:0] xfer_col,
    input logic             wr_take,
    input logic [DQ_W-1:0]  wr_data,
    input logic             dq_oe,
    input logic [DQ_W-1:0]  dq_out,
    input logic             fp_mode
);

    p_act_after_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !mode_load) |=> (cmd == CMD_ACT));

    p_mrs_after_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_load && req_ready) |=> (cmd == CMD_MRS));

    p_busy_on_act_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_ACT) |-> !req_ready);

    p_take_in_slot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_take |-> xfer_vld);

    p_beat_follows_take_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_take |=> (dq_oe && dq_out == $past(wr_data)));

    p_bst_after_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_BST) |-> ($past(xfer_vld) && $past(stop_req) && !xfer_vld));

    p_fp_col_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_vld && $past(xfer_vld) && fp_mode) |-> (xfer_col == $past(xfer_col) + COL_W'(1)));

    p_quiet_bus_in_burst_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_vld && $past(xfer_vld)) |-> (cmd == CMD_NOP));

endmodule

bind sdram_burst_seq sdram_seq_chk #(.DQ_W(DQ_W), .COL_W(COL_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .mode_load (mode_load),
    .stop_req  (stop_req),
    .cmd       (cmd),
    .xfer_vld  (xfer_vld),
    .xfer_col  (xfer_col),
    .wr_take   (wr_take),
    .wr_data   (wr_data),
    .dq_oe     (dq_oe),
    .dq_out    (dq_out),
    .fp_mode   (fp_mode)
);

// File: tb/tb_sdram_burst_seq.sv
`timescale 1ns/1ps
module tb_sdram_burst_seq;

    localparam int DQ_W = 16, BA_W = 2, ROW_W = 13, COL_W = 9, ADDR_W = 14;
    localparam int TRCD = 3, CL = 3;
    localparam int ROWLEN = 1 << COL_W;
    localparam logic [2:0] C_NOP = 3'd0, C_ACT = 3'd1, C_RD = 3'd2,
                           C_WR = 3'd3, C_MRS = 3'd4, C_BST = 3'd5;

    logic clk = 1'b0, rst_n = 1'b0;
    logic mode_load = 1'b0;
    logic [ADDR_W-1:0] mode_value = '0;
    logic req_valid = 1'b0, req_write = 1'b0, stop_req = 1'b0;
    logic req_ready;
    logic [BA_W-1:0] req_bank = '0;
    logic [ROW_W-1:0] req_row = '0;
    logic [COL_W-1:0] req_col = '0;
    logic [DQ_W-1:0] wr_data = '0, dq_in = '0;
    logic wr_take, rd_valid, xfer_vld, dq_oe;
    logic [DQ_W-1:0] rd_data, dq_out;
    logic [COL_W-1:0] xfer_col;
    logic [2:0] cmd;
    logic [BA_W-1:0] ba;
    logic [ADDR_W-1:0] addr;

    sdram_burst_seq #(.DQ_W(DQ_W), .BA_W(BA_W), .ROW_W(ROW_W), .COL_W(COL_W),
                      .ADDR_W(ADDR_W), .TRCD(TRCD), .CL(CL)) dut (
        .clk(clk), .rst_n(rst_n), .mode_load(mode_load), .mode_value(mode_value),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
        .stop_req(stop_req), .wr_data(wr_data), .wr_take(wr_take),
        .rd_valid(rd_valid), .rd_data(rd_data), .xfer_vld(xfer_vld),
        .xfer_col(xfer_col), .cmd(cmd), .ba(ba), .addr(addr),
        .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in));

    always #2 clk = ~clk;

    int cyc = 0;
    int n_chk = 0, n_fail = 0;
    bit model_on = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // Reference schedule, indexed by cycle
    logic [2:0]        e_cmd[int];
    logic [BA_W-1:0]   e_ba[int];
    logic [ADDR_W-1:0] e_addr[int];
    string             e_ctag[int];
    int                e_xcol[int];
    string             e_xtag[int];
    bit                e_wt[int];
    logic [DQ_W-1:0]   e_dq[int];
    logic [DQ_W-1:0]   e_rd[int];
    logic [DQ_W-1:0]   dev_dq[int];
    bit                e_busy[int];

    int  m_len = 1;
    bit  m_fp = 0, m_single = 0;

    function automatic logic [DQ_W-1:0] wfun(input int c);
        return DQ_W'(32'h3000 ^ (c * 7));
    endfunction
    function automatic logic [DQ_W-1:0] pat(input int col);
        return DQ_W'(32'hC000 | col);
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s at cycle %0d: actual %0h expected %0h", tag, what, cyc, act, exp);
        end
    endtask

    // Per-cycle comparison against the schedule, plus the device read model
    always @(negedge clk) begin
        if (model_on) begin
            logic [2:0] ec;
            string t;
            ec = e_cmd.exists(cyc) ? e_cmd[cyc] : C_NOP;
            t  = e_ctag.exists(cyc) ? e_ctag[cyc] : "R12";
            chk(cmd == ec, t, "cmd", cmd, ec);
            if (ec != C_NOP && ec != C_BST) begin
                chk(addr == e_addr[cyc], t, "addr", addr, e_addr[cyc]);
                if (ec != C_MRS) chk(ba == e_ba[cyc], t, "ba", ba, e_ba[cyc]);
            end
            t = e_xtag.exists(cyc) ? e_xtag[cyc] : "R6";
            chk(xfer_vld == e_xcol.exists(cyc), t, "xfer_vld", xfer_vld, e_xcol.exists(cyc));
            if (e_xcol.exists(cyc)) chk(xfer_col == COL_W'(e_xcol[cyc]), t, "xfer_col", xfer_col, e_xcol[cyc]);
            chk(wr_take == e_wt.exists(cyc), "R9", "wr_take", wr_take, e_wt.exists(cyc));
            chk(dq_oe == e_dq.exists(cyc), "R9", "dq_oe", dq_oe, e_dq.exists(cyc));
            if (e_dq.exists(cyc)) chk(dq_out == e_dq[cyc], "R9", "dq_out", dq_out, e_dq[cyc]);
            chk(rd_valid == e_rd.exists(cyc), "R11", "rd_valid", rd_valid, e_rd.exists(cyc));
            if (e_rd.exists(cyc)) chk(rd_data == e_rd[cyc], "R11", "rd_data", rd_data, e_rd[cyc]);
            chk(req_ready == !e_busy.exists(cyc), "R12", "req_ready", req_ready, !e_busy.exists(cyc));
        end
        dq_in   <= dev_dq.exists(cyc) ? dev_dq[cyc] : DQ_W'(32'hE000 ^ cyc);
        wr_data <= wfun(cyc);
    end

    task automatic set_mode(input logic [2:0] code, input logic [1:0] wm, input bit with_req);
        int c;
        @(negedge clk);
        c = cyc;
        mode_load  = 1'b1;
        mode_value = ADDR_W'({wm, 8'h00}) | ADDR_W'(code);
        req_valid  = with_req;  // R2: load wins, no activate may follow
        req_row    = 13'h1ABC;
        e_cmd[c+1] = C_MRS; e_addr[c+1] = mode_value; e_ctag[c+1] = "R2";
        case (code)
            3'd1: begin m_len = 2; m_fp = 0; end
            3'd2: begin m_len = 4; m_fp = 0; end
            3'd3: begin m_len = 8; m_fp = 0; end
            3'd7: begin m_len = ROWLEN; m_fp = 1; end
            default: begin m_len = 1; m_fp = 0; end  // R5 unused codes
        endcase
        m_single = (wm != 2'b00);
        @(negedge clk);
        mode_load = 1'b0;
        req_valid = 1'b0;
    endtask

    // One burst; fp_beats sets where stop lands for full-row bursts,
    // stray drives stop_req into a fixed burst (R8)
    task automatic run(input bit wr, input logic [BA_W-1:0] bk, input int row,
                       input int col, input int fp_beats, input bit stray, input string xt);
        int a, t, n, base, ci;
        bit fpb;
        @(negedge clk);
        a = cyc;
        req_valid = 1'b1; req_write = wr; req_bank = bk;
        req_row = ROW_W'(row); req_col = COL_W'(col);
        fpb = m_fp && !(wr && m_single);
        n = (wr && m_single) ? 1 : (fpb ? fp_beats : m_len);
        e_cmd[a+1] = C_ACT; e_ba[a+1] = bk; e_addr[a+1] = ADDR_W'(row); e_ctag[a+1] = "R3";
        t = a + 1 + TRCD;
        e_cmd[t] = wr ? C_WR : C_RD; e_ba[t] = bk; e_addr[t] = ADDR_W'(col); e_ctag[t] = "R4";
        base = fpb ? 0 : (col & ~(m_len - 1));
        for (int i = 0; i < n; i++) begin
            ci = fpb ? ((col + i) % ROWLEN) : (base | ((col + i) & (m_len - 1)));
            e_xcol[t+i] = ci; e_xtag[t+i] = xt;
            if (wr) begin
                e_wt[t+i] = 1'b1;
                e_dq[t+i+1] = wfun(t + i);
            end else begin
                dev_dq[t+CL+i] = pat(ci);
                e_rd[t+CL+1+i] = pat(ci);
            end
        end
        for (int c = a + 1; c <= t + n - 1; c++) e_busy[c] = 1'b1;
        if (fpb) begin e_cmd[t+n] = C_BST; e_ctag[t+n] = "R7"; end
        @(negedge clk);
        req_row = ROW_W'(row + 1);  // R12: still requesting while busy, must be ignored
        @(negedge clk);
        req_valid = 1'b0;
        if (fpb || stray) begin
            while (cyc < (fpb ? t + n - 1 : t)) @(negedge clk);
            stop_req = 1'b1;
            @(negedge clk);
            stop_req = 1'b0;
        end
        while (cyc < t + CL + n + 3) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(cmd == C_NOP, "R1", "cmd", cmd, C_NOP);
        chk(!dq_oe && !rd_valid && !xfer_vld && !wr_take, "R1", "outputs idle",
            {dq_oe, rd_valid, xfer_vld, wr_take}, 0);
        chk(req_ready, "R1", "req_ready", req_ready, 1);
        model_on = 1;

        run(0, 2'd1, 5, 13, 0, 0, "R1");          // R1: default length 1
        set_mode(3'd1, 2'b00, 0);
        run(0, 2'd2, 7, 13, 0, 0, "R6");          // R6: BL2 wrap 13,12
        set_mode(3'd2, 2'b00, 0);
        run(0, 2'd3, 9, 6, 0, 0, "R6");           // R6: BL4 6,7,4,5
        set_mode(3'd3, 2'b00, 0);
        run(1, 2'd0, 11, 21, 0, 1, "R8");         // R8: stray stop in BL8 write
        run(0, 2'd1, 12, 0, 0, 1, "R8");          // R8: stray stop in BL8 read
        set_mode(3'd7, 2'b00, 0);
        run(0, 2'd2, 20, 508, 6, 0, "R7");        // R7: wraps 511 -> 0
        run(1, 2'd3, 21, 3, 3, 0, "R7");          // R7: full-row write
        run(0, 2'd0, 22, 40, 1, 0, "R7");         // R7: stop on first beat
        set_mode(3'd5, 2'b00, 0);
        run(0, 2'd1, 30, 9, 0, 0, "R5");          // R5: unused code -> 1 beat
        set_mode(3'd3, 2'b01, 0);
        run(1, 2'd2, 31, 5, 0, 0, "R10");         // R10: single write
        run(0, 2'd2, 31, 5, 0, 0, "R10");         // R10: read still 8 beats
        set_mode(3'd7, 2'b10, 0);
        run(1, 2'd3, 32, 100, 0, 0, "R10");       // R10: single write, full-row mode
        set_mode(3'd2, 2'b00, 1);                 // R2: load beats request
        run(1, 2'd1, 33, 10, 0, 0, "R5");         // R5: BL4 write 10,11,8,9
        repeat (4) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule